// File: doc/BRIEF.md
# USB Host Register Unit

This unit is the software-facing front of a small full-speed USB host engine. A processor reaches it through a Wishbone slave port with 32-bit words. The unit holds the words that steer the host engine and the PHY: a control word, a transfer length, a transfer token, and an interrupt mask. It also shows the engine's state through read-only words: line state, frame time, receive error and receive result. The FIFOs, the packet engine and any clock-domain crossing sit outside. The unit only sends them registered strobes and byte values.

Interrupts come from four causes: start of frame, transfer done, error, and device detect. Device detect is raised when the line leaves SE0. Software enables causes through a mask register and clears them by writing ones to an acknowledge register. A single interrupt output is raised while any enabled cause is pending. A token write carrying the start bit raises a pending flag. The engine sees the flag as its request and drops it with an accept pulse. A single data port at word offset 0x20 pushes a byte toward the transmit FIFO on a write. On a read it returns the head byte of the receive FIFO and pops it.

Top module: `usbh_regbank`

## Requirements
- R1: After reset, all stored registers, pending flags and the interrupt output are 0. The PHY control outputs are 0, and `wb_ack_o` and every strobe are low.
- R2: Each Wishbone request (cyc and stb high while ack is low) is answered by `wb_ack_o` high for exactly one cycle, in the clock cycle after the request is sampled. Read data is valid in that ack cycle.
- R3: The control word is at byte address 0x00. Its bits drive the PHY outputs: bit 7 is the D- pulldown, bit 6 the D+ pulldown, bit 5 termination select, bits 4:3 transceiver select, bits 2:1 output mode, and bit 0 enables start-of-frame generation. Bits 7:0 read back as written.
- R4: Writing 0x00 with bit 8 set gives a `tx_flush_o` pulse for exactly one cycle, in the ack cycle. Bit 8 always reads as 0.
- R5: The status word at 0x04 reads as follows: frame time in bits 31:16, the sticky receive-error flag in bit 2, the line state in bits 1:0, and 0 elsewhere.
- R6: Interrupt bits use the same layout in status (0x0C), mask (0x10) and acknowledge (0x08): 3 is device detect, 2 is error, 1 is done, and 0 is start of frame. A cause event sets its status bit. Writing 1 to an acknowledge bit clears that status bit. If a set and an acknowledge hit the same bit in one cycle, the set wins. The acknowledge word reads as 0.
- R7: `irq_o` is 1 exactly when the interrupt status ANDed with the mask is nonzero.
- R8: The device-detect cause fires once when the line state changes from 00 (SE0) to any nonzero value. A change between two nonzero values does not fire it, and neither does a line that stays nonzero.
- R9: A write to the token word (0x18) with bit 31 set raises `xfer_pending_o`. The flag stays high until `xfer_accept_i` is seen. If a start write and an accept occur in the same cycle, the flag stays high. The flag reads back in bit 31 of the token word and of the receive-status word.
- R10: A write to 0x20 gives a one-cycle `tx_push_o` pulse in the ack cycle, with `tx_byte_o` equal to write bits 7:0. A read of 0x20 returns `rx_byte_i` in bits 7:0 with 0 above, and gives a one-cycle `rx_pop_o` pulse in the ack cycle.
- R11: Writes to 0x04, 0x0C and 0x1C have no effect. Reads of unmapped addresses return 0, and so do reads of addresses with bits 1:0 not 00.
- R12: A `rx_error_i` pulse sets the receive-error flag. The flag clears at a token write with the start bit set, and is not cleared by a token write without it.
- R13: The length word (0x14) holds bits 15:0 and drives `xfer_len_o`. The token word holds the following fields, which drive their outputs and read back in place, with other bits 0:
  - bit 30: IN
  - bit 29: ACK
  - bit 28: DATA1
  - bits 23:16: PID
  - bits 15:9: device
  - bits 8:5: endpoint
- R14: The receive-status word at 0x1C reads as follows: pending in bit 31, CRC error in bit 30, timeout in bit 29, engine idle in bit 28, response PID in bits 23:16, received count in bits 15:0, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| irq_o | output | 1 | Interrupt request |
| line_state_i | input | 2 | Bus line state |
| frame_time_i | input | 16 | Current frame time |
| rx_error_i | input | 1 | Receive error pulse |
| sof_evt_i | input | 1 | Start-of-frame event pulse |
| done_evt_i | input | 1 | Transfer-done event pulse |
| err_evt_i | input | 1 | Error event pulse |
| xfer_accept_i | input | 1 | Engine accepts the pending request |
| eng_idle_i | input | 1 | Engine idle |
| rx_crc_err_i | input | 1 | CRC error seen |
| rx_timeout_i | input | 1 | Response timeout seen |
| rx_pid_i | input | 8 | Response PID |
| rx_count_i | input | 16 | Received byte count |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_byte_o | output | 8 | Byte to push |
| tx_flush_o | output | 1 | Transmit FIFO flush strobe |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| rx_byte_i | input | 8 | Receive FIFO head byte |
| sof_enable_o | output | 1 | Start-of-frame generation enable |
| phy_opmode_o | output | 2 | PHY output mode |
| phy_xcvrsel_o | output | 2 | PHY transceiver select |
| phy_termsel_o | output | 1 | PHY termination select |
| phy_dp_pulldown_o | output | 1 | D+ pulldown enable |
| phy_dm_pulldown_o | output | 1 | D- pulldown enable |
| xfer_len_o | output | 16 | Transmit length |
| xfer_pending_o | output | 1 | Transfer request pending |
| xfer_in_o | output | 1 | IN direction |
| xfer_ack_o | output | 1 | Answer IN data with ACK |
| xfer_data1_o | output | 1 | DATA1 toggle |
| xfer_pid_o | output | 8 | Token PID |
| xfer_dev_o | output | 7 | Device address |
| xfer_ep_o | output | 4 | Endpoint number |

## Verification
The hardest cases to bring about from the ports are two collisions within one clock cycle. In the first, an event and an acknowledge write target the same interrupt bit. In the second, a start write meets an engine accept. For both, the bench raises the event or accept pulse at the same falling edge where it presents the bus request. Both are then sampled by the same rising edge, which reaches the set-wins rule directly. Around this, the bench sweeps all 512 control values and all 256 pairs of pending causes and mask. Device detect takes part in the sweep by returning the line to SE0 between rounds.

// File: rtl/usbh_reg_pkg.sv
package usbh_reg_pkg;

  localparam int WORD_W = 32;
  localparam int IRQ_N  = 4;
  localparam int FT_W   = 16;
  localparam int LEN_W  = 16;
  localparam int CNT_W  = 16;

  // word indices (byte address / 4)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_IACK  = 2;
  localparam int IDX_ISTS  = 3;
  localparam int IDX_IMSK  = 4;
  localparam int IDX_LEN   = 5;
  localparam int IDX_TOK   = 6;
  localparam int IDX_RXS   = 7;
  localparam int IDX_DATA  = 8;
  localparam int NREG      = 9;

  // interrupt cause bit positions
  localparam int IRQ_SOF  = 0;
  localparam int IRQ_DONE = 1;
  localparam int IRQ_ERR  = 2;
  localparam int IRQ_DET  = 3;

  localparam int CTRL_FLUSH = 8;
  localparam int TOK_START  = 31;

  // packed order equals control bits 7..0
  typedef struct packed {
    logic       dm_pd;
    logic       dp_pd;
    logic       term;
    logic [1:0] xcvr;
    logic [1:0] opmode;
    logic       sof_en;
  } phy_ctrl_t;

  typedef struct packed {
    logic       dir_in;
    logic       ack;
    logic       data1;
    logic [7:0] pid;
    logic [6:0] dev;
    logic [3:0] ep;
  } token_t;

  function automatic logic [WORD_W-1:0] status_word(
    input logic [FT_W-1:0] ft, input logic rx_err, input logic [1:0] ls);
    status_word = {ft, 13'd0, rx_err, ls};
  endfunction

  function automatic logic [WORD_W-1:0] token_word(
    input logic pend, input token_t t);
    token_word = {pend, t.dir_in, t.ack, t.data1, 4'd0, t.pid, t.dev, t.ep, 5'd0};
  endfunction

  function automatic logic [WORD_W-1:0] rxstat_word(
    input logic pend, input logic crc, input logic tmo, input logic idle,
    input logic [7:0] pid, input logic [CNT_W-1:0] cnt);
    rxstat_word = {pend, crc, tmo, idle, 4'd0, pid, cnt};
  endfunction

  function automatic token_t token_from_word(input logic [WORD_W-1:0] w);
    token_t t;
    t.dir_in = w[30];
    t.ack    = w[29];
    t.data1  = w[28];
    t.pid    = w[23:16];
    t.dev    = w[15:9];
    t.ep     = w[8:5];
    return t;
  endfunction

endpackage

// File: rtl/usbh_bus_decode.sv
module usbh_bus_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  output logic              req_o,
  output logic [NREG-1:0]   wr_sel_o,
  output logic [NREG-1:0]   rd_sel_o,
  output logic              ack_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic             ack_q;
  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign req_o   = cyc_i & stb_i & ~ack_q;
  assign aligned = (adr_i[1:0] == 2'b00);
  assign idx     = adr_i[ADDR_W-1:2];

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign wr_sel_o[k] = req_o &  we_i & aligned & (idx == IDX_W'(k));
    assign rd_sel_o[k] = req_o & ~we_i & aligned & (idx == IDX_W'(k));
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= req_o;
  end

  assign ack_o = ack_q;

  // R2: ack lasts a single cycle
  assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_q |=> !ack_q);

  // R2: ack only answers a strobe seen one cycle before
  assert_ack_cause_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ack_q) |-> $past(cyc_i && stb_i));

  // R11: at most one register is hit per request
  assert_sel_onehot_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({wr_sel_o, rd_sel_o}));

endmodule

// File: rtl/usbh_irq_unit.sv
module usbh_irq_unit #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] set_i,
  input  logic         ack_wr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);

  logic [N-1:0] sts_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr;

  assign clr = ack_wr_i ? wdata_i : '0;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) sts_q[k] <= 1'b0;
      else       sts_q[k] <= set_i[k] | (sts_q[k] & ~clr[k]);
    end

    // R6: an event always leaves its bit set, even against an acknowledge
    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      set_i[k] |=> sts_q[k]);

    // R6: acknowledge without a competing event clears the bit
    assert_ack_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr[k] && !set_i[k]) |=> !sts_q[k]);
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)          mask_q <= '0;
    else if (mask_wr_i) mask_q <= wdata_i;
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
  assign irq_o  = |(sts_q & mask_q);

  // R7: interrupt needs both a pending cause and an enabled mask
  assert_irq_needs_cause_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> ((|sts_q) && (|mask_q)));

endmodule

// File: rtl/usbh_xfer_regs.sv
module usbh_xfer_regs
  import usbh_reg_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              len_wr_i,
  input  logic              tok_wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic              rx_error_i,
  output logic [LW-1:0]     len_o,
  output token_t            tok_o,
  output logic              pend_o,
  output logic              rx_err_o,
  output logic              start_evt_o
);

  logic [LW-1:0] len_q;
  token_t        tok_q;
  logic          pend_q;
  logic          rx_err_q;
  logic          start_evt;

  assign start_evt = tok_wr_i & wdata_i[TOK_START];

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      len_q    <= '0;
      tok_q    <= '0;
      pend_q   <= 1'b0;
      rx_err_q <= 1'b0;
    end else begin
      if (len_wr_i) len_q <= wdata_i[LW-1:0];
      if (tok_wr_i) tok_q <= token_from_word(wdata_i);
      pend_q   <= start_evt | (pend_q & ~accept_i);
      rx_err_q <= rx_error_i | (rx_err_q & ~start_evt);
    end
  end

  assign len_o       = len_q;
  assign tok_o       = tok_q;
  assign pend_o      = pend_q;
  assign rx_err_o    = rx_err_q;
  assign start_evt_o = start_evt;

  // R9: pending holds until the engine accepts
  assert_pend_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_q && !accept_i) |=> pend_q);

  // R9: accept without a new start drops the request
  assert_pend_drop_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (accept_i && !start_evt) |=> !pend_q);

  // R12: a new transfer start clears the sticky receive error
  assert_rxerr_clear_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_evt && !rx_error_i) |=> !rx_err_q);

  // R12: the error flag is sticky between starts
  assert_rxerr_hold_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    (rx_err_q && !start_evt) |=> rx_err_q);

endmodule

// File: rtl/usbh_regbank.sv
module usbh_regbank
  import usbh_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic              irq_o,
  input  logic [1:0]        line_state_i,
  input  logic [15:0]       frame_time_i,
  input  logic              rx_error_i,
  input  logic              sof_evt_i,
  input  logic              done_evt_i,
  input  logic              err_evt_i,
  input  logic              xfer_accept_i,
  input  logic              eng_idle_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_timeout_i,
  input  logic [7:0]        rx_pid_i,
  input  logic [15:0]       rx_count_i,
  output logic              tx_push_o,
  output logic [7:0]        tx_byte_o,
  output logic              tx_flush_o,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_byte_i,
  output logic              sof_enable_o,
  output logic [1:0]        phy_opmode_o,
  output logic [1:0]        phy_xcvrsel_o,
  output logic              phy_termsel_o,
  output logic              phy_dp_pulldown_o,
  output logic              phy_dm_pulldown_o,
  output logic [15:0]       xfer_len_o,
  output logic              xfer_pending_o,
  output logic              xfer_in_o,
  output logic              xfer_ack_o,
  output logic              xfer_data1_o,
  output logic [7:0]        xfer_pid_o,
  output logic [6:0]        xfer_dev_o,
  output logic [3:0]        xfer_ep_o
);

  logic              req;
  logic [NREG-1:0]   wr_sel;
  logic [NREG-1:0]   rd_sel;
  logic              ack;

  usbh_bus_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cyc_i    (wb_cyc_i),
    .stb_i    (wb_stb_i),
    .we_i     (wb_we_i),
    .adr_i    (wb_adr_i),
    .req_o    (req),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel),
    .ack_o    (ack)
  );

  // device detect: line leaves SE0
  logic line_live;
  logic line_live_q;
  logic det_evt;

  assign line_live = (line_state_i != 2'b00);
  assign det_evt   = line_live & ~line_live_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) line_live_q <= 1'b0;
    else       line_live_q <= line_live;
  end

  logic [IRQ_N-1:0] irq_set;
  logic [IRQ_N-1:0] irq_sts;
  logic [IRQ_N-1:0] irq_mask;

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_SOF]  = sof_evt_i;
    irq_set[IRQ_DONE] = done_evt_i;
    irq_set[IRQ_ERR]  = err_evt_i;
    irq_set[IRQ_DET]  = det_evt;
  end

  usbh_irq_unit #(.N(IRQ_N)) u_irq (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .set_i     (irq_set),
    .ack_wr_i  (wr_sel[IDX_IACK]),
    .mask_wr_i (wr_sel[IDX_IMSK]),
    .wdata_i   (wb_dat_i[IRQ_N-1:0]),
    .sts_o     (irq_sts),
    .mask_o    (irq_mask),
    .irq_o     (irq_o)
  );

  logic [LEN_W-1:0] len_q;
  token_t           tok_q;
  logic             pend;
  logic             rx_err;
  logic             start_evt;

  usbh_xfer_regs #(.LW(LEN_W)) u_xfer (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .len_wr_i    (wr_sel[IDX_LEN]),
    .tok_wr_i    (wr_sel[IDX_TOK]),
    .wdata_i     (wb_dat_i),
    .accept_i    (xfer_accept_i),
    .rx_error_i  (rx_error_i),
    .len_o       (len_q),
    .tok_o       (tok_q),
    .pend_o      (pend),
    .rx_err_o    (rx_err),
    .start_evt_o (start_evt)
  );

  logic unused_wdata;
  assign unused_wdata = ^wb_dat_i[27:24];

  // control word, strobes and read data
  phy_ctrl_t   ctrl_q;
  logic        flush_q;
  logic        push_q;
  logic        pop_q;
  logic [7:0]  txb_q;
  logic [31:0] dat_q;
  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (rd_sel[IDX_CTRL]) rd_word = {24'd0, ctrl_q};
    if (rd_sel[IDX_STAT]) rd_word = status_word(frame_time_i, rx_err, line_state_i);
    if (rd_sel[IDX_ISTS]) rd_word = {{(32-IRQ_N){1'b0}}, irq_sts};
    if (rd_sel[IDX_IMSK]) rd_word = {{(32-IRQ_N){1'b0}}, irq_mask};
    if (rd_sel[IDX_LEN])  rd_word = {{(32-LEN_W){1'b0}}, len_q};
    if (rd_sel[IDX_TOK])  rd_word = token_word(pend, tok_q);
    if (rd_sel[IDX_RXS])  rd_word = rxstat_word(pend, rx_crc_err_i, rx_timeout_i,
                                                eng_idle_i, rx_pid_i, rx_count_i);
    if (rd_sel[IDX_DATA]) rd_word = {24'd0, rx_byte_i};
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      flush_q <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      txb_q   <= '0;
      dat_q   <= '0;
    end else begin
      if (wr_sel[IDX_CTRL]) ctrl_q <= phy_ctrl_t'(wb_dat_i[7:0]);
      flush_q <= wr_sel[IDX_CTRL] & wb_dat_i[CTRL_FLUSH];
      push_q  <= wr_sel[IDX_DATA];
      pop_q   <= rd_sel[IDX_DATA];
      if (wr_sel[IDX_DATA]) txb_q <= wb_dat_i[7:0];
      if (req) dat_q <= rd_word;
    end
  end

  assign wb_dat_o          = dat_q;
  assign wb_ack_o          = ack;
  assign tx_push_o         = push_q;
  assign tx_byte_o         = txb_q;
  assign tx_flush_o        = flush_q;
  assign rx_pop_o          = pop_q;
  assign sof_enable_o      = ctrl_q.sof_en;
  assign phy_opmode_o      = ctrl_q.opmode;
  assign phy_xcvrsel_o     = ctrl_q.xcvr;
  assign phy_termsel_o     = ctrl_q.term;
  assign phy_dp_pulldown_o = ctrl_q.dp_pd;
  assign phy_dm_pulldown_o = ctrl_q.dm_pd;
  assign xfer_len_o        = len_q;
  assign xfer_pending_o    = pend;
  assign xfer_in_o         = tok_q.dir_in;
  assign xfer_ack_o        = tok_q.ack;
  assign xfer_data1_o      = tok_q.data1;
  assign xfer_pid_o        = tok_q.pid;
  assign xfer_dev_o        = tok_q.dev;
  assign xfer_ep_o         = tok_q.ep;

  // R4: flush is a single-cycle pulse
  assert_flush_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_flush_o |=> !tx_flush_o);

  // R10: FIFO strobes coincide with the bus acknowledge
  assert_push_ack_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_push_o |-> wb_ack_o);
  assert_pop_ack_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_pop_o |-> wb_ack_o);

  // R8: leaving SE0 raises the detect cause
  assert_detect_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_live && !line_live_q) |=> irq_sts[IRQ_DET]);

  // R9: a start write always leaves a pending request
  assert_start_pend_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    start_evt |=> xfer_pending_o);

endmodule

// File: tb/usbh_regbank_test.sv
module usbh_regbank_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        cyc = 0, stb = 0, we = 0;
  logic [7:0]  adr = 0;
  logic [31:0] wdat = 0;
  logic [31:0] dat;
  logic        ack, irq;
  logic [1:0]  ls = 0;
  logic [15:0] ft = 0;
  logic        rxe = 0, sof = 0, done = 0, err = 0, accept = 0;
  logic        idle = 0, crc = 0, tmo = 0;
  logic [7:0]  rpid = 0;
  logic [15:0] rcnt = 0;
  logic        push, flush, pop;
  logic [7:0]  txb;
  logic [7:0]  rxb = 0;
  logic        sofen, termsel, dppd, dmpd;
  logic [1:0]  opmode, xcvr;
  logic [15:0] xlen;
  logic        pend, xin, xack, xd1;
  logic [7:0]  xpid;
  logic [6:0]  xdev;
  logic [3:0]  xep;

  usbh_regbank uut (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat), .wb_ack_o(ack), .irq_o(irq),
    .line_state_i(ls), .frame_time_i(ft), .rx_error_i(rxe), .sof_evt_i(sof),
    .done_evt_i(done), .err_evt_i(err), .xfer_accept_i(accept), .eng_idle_i(idle),
    .rx_crc_err_i(crc), .rx_timeout_i(tmo), .rx_pid_i(rpid), .rx_count_i(rcnt),
    .tx_push_o(push), .tx_byte_o(txb), .tx_flush_o(flush), .rx_pop_o(pop),
    .rx_byte_i(rxb), .sof_enable_o(sofen), .phy_opmode_o(opmode),
    .phy_xcvrsel_o(xcvr), .phy_termsel_o(termsel), .phy_dp_pulldown_o(dppd),
    .phy_dm_pulldown_o(dmpd), .xfer_len_o(xlen), .xfer_pending_o(pend),
    .xfer_in_o(xin), .xfer_ack_o(xack), .xfer_data1_o(xd1), .xfer_pid_o(xpid),
    .xfer_dev_o(xdev), .xfer_ep_o(xep)
  );

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;
  logic [31:0] rdat;
  logic got_ack, got_push, got_flush, got_pop;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(posedge clk);
    @(negedge clk);
    got_ack = ack; got_push = push; got_flush = flush; got_pop = pop;
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input logic [7:0] a);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    @(posedge clk);
    @(negedge clk);
    got_ack = ack; got_pop = pop; got_push = push; rdat = dat;
    cyc = 0; stb = 0;
  endtask

  // one round of cause events given as an interrupt bit pattern
  task automatic fire(input logic [3:0] s);
    @(negedge clk);
    sof = s[0]; done = s[1]; err = s[2]; ls = s[3] ? 2'b01 : 2'b00;
    @(negedge clk);
    sof = 0; done = 0; err = 0; ls = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ack == 0 && irq == 0 && push == 0 && pop == 0 && flush == 0, "R1 strobes",
        {ack, irq, push, pop, flush}, 0);
    chk({sofen, opmode, xcvr, termsel, dppd, dmpd} == 0 && pend == 0 && xlen == 0,
        "R1 outputs", {sofen, opmode, xcvr, termsel, dppd, dmpd, pend}, 0);
    rst = 0;
    wb_read(8'h00); chk(rdat == 0, "R1 ctrl", rdat, 0);
    wb_read(8'h0C); chk(rdat == 0, "R1 irq sts", rdat, 0);
    wb_read(8'h10); chk(rdat == 0, "R1 irq mask", rdat, 0);
    wb_read(8'h18); chk(rdat == 0, "R1 token", rdat, 0);

    // R2: one-cycle ack
    wb_write(8'h14, 32'h0);
    chk(got_ack == 1, "R2 ack raised", got_ack, 1);
    @(negedge clk);
    chk(ack == 0, "R2 ack single", ack, 0);

    // R3 / R4: sweep of the control word including the flush bit
    for (int v = 0; v < 512; v++) begin
      wb_write(8'h00, 32'(v));
      chk(got_flush == v[8], "R4 flush pulse", got_flush, v[8]);
      chk({dmpd, dppd, termsel, xcvr, opmode, sofen} == v[7:0], "R3 phy outputs",
          {dmpd, dppd, termsel, xcvr, opmode, sofen}, v[7:0]);
      @(negedge clk);
      chk(flush == 0, "R4 flush single", flush, 0);
      wb_read(8'h00);
      chk(rdat == (v & 32'hFF), "R3 R4 ctrl readback", rdat, v & 32'hFF);
    end

    // R5 / R12: status word with sticky receive error
    ft = 16'hBB80; ls = 2'b10;
    @(negedge clk); rxe = 1; @(negedge clk); rxe = 0;
    wb_read(8'h04);
    chk(rdat == 32'hBB80_0006, "R5 status", rdat, 32'hBB80_0006);
    wb_write(8'h18, 32'h0000_0000);
    wb_read(8'h04);
    chk(rdat[2] == 1, "R12 err kept without start", rdat[2], 1);
    wb_write(8'h18, 32'h8000_0000);
    wb_read(8'h04);
    chk(rdat == 32'hBB80_0002, "R12 err cleared by start", rdat, 32'hBB80_0002);
    @(negedge clk); accept = 1; @(negedge clk); accept = 0;
    ls = 2'b00;
    // clear the detect cause raised by the line change above
    repeat (2) @(negedge clk);
    wb_write(8'h08, 32'hF);

    // R11: writes to read-only words ignored, unmapped reads zero
    wb_write(8'h0C, 32'hF);
    wb_read(8'h0C); chk(rdat == 0, "R11 irq sts ro", rdat, 0);
    wb_write(8'h04, 32'hFFFF_FFFF);
    wb_read(8'h04); chk(rdat == 32'hBB80_0000, "R11 status ro", rdat, 32'hBB80_0000);
    wb_write(8'h1C, 32'hFFFF_FFFF);
    chk(pend == 0, "R11 rxstat ro", pend, 0);
    wb_read(8'h24); chk(rdat == 0, "R11 unmapped 24", rdat, 0);
    wb_read(8'hFC); chk(rdat == 0, "R11 unmapped FC", rdat, 0);
    wb_read(8'h01); chk(rdat == 0 && got_pop == 0, "R11 unaligned", rdat, 0);
    wb_read(8'h08); chk(rdat == 0, "R6 ack reads 0", rdat, 0);

    // R6 / R7 / R8: every cause pattern against every mask
    for (int m = 0; m < 16; m++) begin
      wb_write(8'h10, 32'(m));
      for (int s = 0; s < 16; s++) begin
        fire(4'(s));
        @(negedge clk);
        chk(irq == ((s & m) != 0), "R7 irq level", irq, (s & m) != 0);
        wb_read(8'h0C);
        chk(rdat == 32'(s), "R6 R8 irq status", rdat, s);
        wb_write(8'h08, 32'(s));
        wb_read(8'h0C);
        chk(rdat == 0 && irq == 0, "R6 ack clears", rdat, 0);
      end
    end

    // R6: partial acknowledge
    fire(4'hF);
    wb_write(8'h08, 32'h5);
    wb_read(8'h0C); chk(rdat == 32'hA, "R6 partial ack", rdat, 32'hA);
    wb_write(8'h08, 32'hF);

    // R6: set wins over acknowledge in the same cycle
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 8'h08; wdat = 32'h3; done = 1;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0; done = 0;
    wb_read(8'h0C); chk(rdat == 32'h2, "R6 set wins", rdat, 32'h2);
    wb_write(8'h08, 32'hF);

    // R8: no event between nonzero states or while nonzero
    @(negedge clk); ls = 2'b10;
    repeat (2) @(negedge clk);
    wb_write(8'h08, 32'hF);
    @(negedge clk); ls = 2'b01;
    repeat (4) @(negedge clk);
    wb_read(8'h0C); chk(rdat == 0, "R8 no re-detect", rdat, 0);
    ls = 2'b00; repeat (2) @(negedge clk);

    // R9: pending request handling
    wb_write(8'h18, 32'h8000_0000);
    repeat (5) @(negedge clk);
    chk(pend == 1, "R9 pending held", pend, 1);
    wb_read(8'h1C); chk(rdat[31] == 1, "R9 rxstat pending", rdat[31], 1);
    @(negedge clk); accept = 1; @(negedge clk); accept = 0;
    chk(pend == 0, "R9 accept clears", pend, 0);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 8'h18; wdat = 32'h8000_0000; accept = 1;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0; accept = 0;
    chk(pend == 1, "R9 start beats accept", pend, 1);
    @(negedge clk); accept = 1; @(negedge clk); accept = 0;

    // R10: data port push and pop
    wb_write(8'h20, 32'h0000_01A5);
    chk(got_push == 1 && txb == 8'hA5, "R10 push", {got_push, txb}, 9'h1A5);
    @(negedge clk); chk(push == 0, "R10 push single", push, 0);
    rxb = 8'h3C;
    wb_read(8'h20);
    chk(rdat == 32'h3C && got_pop == 1, "R10 pop data", rdat, 32'h3C);
    @(negedge clk); chk(pop == 0, "R10 pop single", pop, 0);
    wb_read(8'h00); chk(got_pop == 0, "R10 no pop elsewhere", got_pop, 0);

    // R13: length and token fields
    wb_write(8'h14, 32'hFFFF_1234);
    chk(xlen == 16'h1234, "R13 length out", xlen, 16'h1234);
    wb_read(8'h14); chk(rdat == 32'h1234, "R13 length read", rdat, 32'h1234);
    wb_write(8'h18, 32'h5F69_F5FF);
    chk({xin, xack, xd1} == 3'b101 && xpid == 8'h69 && xdev == 7'h7A && xep == 4'hF,
        "R13 token out", {xin, xack, xd1, xpid, xdev, xep}, 0);
    wb_read(8'h18); chk(rdat == 32'h5069_F5E0, "R13 token read", rdat, 32'h5069_F5E0);

    // R14: receive status layout
    crc = 1; tmo = 0; idle = 1; rpid = 8'hD2; rcnt = 16'h0123;
    wb_read(8'h1C); chk(rdat == 32'h50D2_0123, "R14 rxstat", rdat, 32'h50D2_0123);
    crc = 0; tmo = 1; idle = 0;
    wb_read(8'h1C); chk(rdat == 32'h20D2_0123, "R14 rxstat timeout", rdat, 32'h20D2_0123);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule